// File: doc/BRIEF.md
# Interrupt Controller Sleep Handshake Guard

This block keeps the per-core power handshake state of an interrupt distributor and screens every software register write against the handshake and locking rules. Each core has a sleep request bit that software sets or clears and an asleep status bit that follows the request once that core acknowledges. A chip-wide sleep request may be raised only when every core is fully asleep. While any core has its message-interrupt enable set, the shared cache and shareability attribute field is frozen until the chip-wide sleep has completed.

A write that breaks a rule is dropped and reported in a single error record that holds a syndrome code, a severity code and a 9-bit information field. The record keeps the first error until software clears it. Any further error raises an overflow flag and leaves the record as it is. Writes arrive on a plain port that carries a core number, a 3-bit register select and 8 data bits. Every accepted write takes effect on the next clock edge.

Top module: `sleep_guard`

## Requirements
- R1: After reset, every per-core bit, the global request and done flags, the attribute field, the distributor control value and the whole error record read zero.
- R2: A write with select 0 sets the addressed core's sleep request to data bit 0 only if that core's request equals its asleep status. Otherwise the write is dropped and logged with syndrome 0x07, severity 0xF and the core number.
- R3: A core's asleep status takes the value of its sleep request on a clock edge where that core's acknowledge input is high, and holds its value on every other edge.
- R4: A select 4 write with data bit 0 high is dropped and logged with syndrome 0x08, severity 0xF and the writing core's number unless every core has both request and asleep set. The global done flag rises one cycle after an accepted global request while all cores stay asleep.
- R5: The attribute field (select 3, data bits [5:0]) is locked while any core's interrupt enable is set and global done is low. A differing write during the lock is dropped and logged with syndrome 0x05, severity 0xF and the core number. A write of the same value raises no error.
- R6: A select 1 write that would clear a core's interrupt enable (data bit 0 low) while that core is not fully asleep is dropped and logged with syndrome 0x06, severity 0xF and the core number.
- R7: An accepted sleep entry on a core whose group enables (select 2, data bits [1:0]) are nonzero still takes effect. It clears those group enables and logs syndrome 0x09, severity 0xF and the core number.
- R8: A select 5 write to the distributor control value made while the pending input is high is dropped and logged with syndrome 0x0A, severity 0xF and the 8-bit value it tried to write.
- R9: The error record keeps its first entry while valid. A later error sets the overflow flag instead. A select 6 write with data bit 0 high clears both the valid and the overflow flags.
- R10: The information field holds the core number or data value from bit 0 upward, and its unused upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_core | input | CORE_W | Number of the core issuing the write |
| wr_sel | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| core_ack | input | NCORES | Per-core handshake acknowledge |
| dist_pend | input | 1 | Distributor write-pending flag |
| core_req | output | NCORES | Per-core sleep request |
| core_asleep | output | NCORES | Per-core asleep status |
| core_lpi | output | NCORES | Per-core message-interrupt enable |
| core_grp | output | 2*NCORES | Per-core group enables, two bits per core |
| gs_req | output | 1 | Global sleep request |
| gs_done | output | 1 | Global sleep completed |
| attr_lock | output | 1 | Attribute field is locked |
| attr | output | 6 | Shared cache and shareability attributes |
| dist_ctl | output | 8 | Distributor control value |
| err_valid | output | 1 | Error record holds an entry |
| err_ovf | output | 1 | A later error was lost |
| err_syn | output | 8 | Syndrome code |
| err_sev | output | 4 | Severity code |
| err_info | output | 9 | Core number or data, packed from bit 0 |

## Verification
Most internal faults show up one cycle after the write that exposes them. A wrong completion compare in a core's handshake would either drop a legal sleep change or let an illegal one through, and either mistake shows on core_req together with a missing or extra error record. A wrong lock term shows in attr or in the record on the first attribute write after a core enables interrupts. A fault in the record's hold logic shows as a changed syndrome or as a missing overflow on the second rejected write.

// File: rtl/sleep_guard_pkg.sv
package sleep_guard_pkg;

    typedef enum logic [2:0] {
        SEL_PSLEEP = 3'd0,
        SEL_LPI    = 3'd1,
        SEL_GRP    = 3'd2,
        SEL_ATTR   = 3'd3,
        SEL_GSLEEP = 3'd4,
        SEL_DCTL   = 3'd5,
        SEL_ERRCLR = 3'd6
    } sel_e;

    localparam logic [7:0] SYN_ATTR_LOCK = 8'h05;
    localparam logic [7:0] SYN_LPI_CLR   = 8'h06;
    localparam logic [7:0] SYN_HS_BUSY   = 8'h07;
    localparam logic [7:0] SYN_GS_FAIL   = 8'h08;
    localparam logic [7:0] SYN_GRP_DROP  = 8'h09;
    localparam logic [7:0] SYN_DCTL_PEND = 8'h0A;
    localparam logic [3:0] SEV_REJECT    = 4'hF;
    localparam int         INFO_W        = 9;

    typedef struct packed {
        logic              hit;
        logic [7:0]        syn;
        logic [3:0]        sev;
        logic [INFO_W-1:0] info;
    } err_ev_t;

    function automatic err_ev_t mk_ev(input logic [7:0] syn, input logic [INFO_W-1:0] info);
        err_ev_t e;
        e.hit  = 1'b1;
        e.syn  = syn;
        e.sev  = SEV_REJECT;
        e.info = info;
        return e;
    endfunction

endpackage

// File: rtl/sleep_guard_core.sv
module sleep_guard_core
    import sleep_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit_i,
    input  logic [2:0] sel_i,
    input  logic [1:0] data_i,
    input  logic       ack_i,
    output logic       req_o,
    output logic       asleep_o,
    output logic       lpi_o,
    output logic [1:0] grp_o,
    output logic       viol_busy_o,
    output logic       viol_lpi_o,
    output logic       ev_grp_o
);
    logic       req_q, asleep_q, lpi_q;
    logic [1:0] grp_q;
    logic       busy, lpi_block, is_ps, is_lpi, is_grp, take_ps;

    assign busy      = req_q != asleep_q;
    assign is_ps     = hit_i && (sel_i == SEL_PSLEEP);
    assign is_lpi    = hit_i && (sel_i == SEL_LPI);
    assign is_grp    = hit_i && (sel_i == SEL_GRP);
    assign lpi_block = lpi_q && !data_i[0] && !(req_q && asleep_q);
    assign take_ps   = is_ps && !busy && (data_i[0] != req_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            asleep_q <= 1'b0;
            lpi_q    <= 1'b0;
            grp_q    <= '0;
        end else begin
            if (ack_i) asleep_q <= req_q;
            if (take_ps) begin
                req_q <= data_i[0];
                if (data_i[0]) grp_q <= '0;
            end
            if (is_lpi && !lpi_block) lpi_q <= data_i[0];
            if (is_grp) grp_q <= data_i;
        end
    end

    assign viol_busy_o = is_ps && busy;
    assign viol_lpi_o  = is_lpi && lpi_block;
    assign ev_grp_o    = take_ps && data_i[0] && (grp_q != 2'b00);
    assign req_o       = req_q;
    assign asleep_o    = asleep_q;
    assign lpi_o       = lpi_q;
    assign grp_o       = grp_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_q != asleep_q) |=> $stable(req_q)); // R2
    AST_ACK_ONLY: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> $stable(asleep_q)); // R3
    AST_GRP_ON_SLEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> (grp_q == 2'b00)); // R7
    AST_LPI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (lpi_q && !(req_q && asleep_q)) |=> lpi_q); // R6
endmodule

// File: rtl/sleep_guard_rec.sv
module sleep_guard_rec
    import sleep_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  err_ev_t           ev_i,
    input  logic              clr_i,
    output logic              valid_o,
    output logic              ovf_o,
    output logic [7:0]        syn_o,
    output logic [3:0]        sev_o,
    output logic [INFO_W-1:0] info_o
);
    logic              valid_q, ovf_q;
    logic [7:0]        syn_q;
    logic [3:0]        sev_q;
    logic [INFO_W-1:0] info_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
            syn_q   <= '0;
            sev_q   <= '0;
            info_q  <= '0;
        end else if (clr_i) begin
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (ev_i.hit) begin
            if (valid_q) begin
                ovf_q <= 1'b1;
            end else begin
                valid_q <= 1'b1;
                syn_q   <= ev_i.syn;
                sev_q   <= ev_i.sev;
                info_q  <= ev_i.info;
            end
        end
    end

    assign valid_o = valid_q;
    assign ovf_o   = ovf_q;
    assign syn_o   = syn_q;
    assign sev_o   = sev_q;
    assign info_o  = info_q;

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !clr_i) |=> ($stable(syn_q) && $stable(info_q) && valid_q)); // R9
    AST_OVF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> valid_q); // R9
endmodule

// File: rtl/sleep_guard.sv
module sleep_guard
    import sleep_guard_pkg::*;
#(
    parameter int NCORES = 4,
    localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CORE_W-1:0]   wr_core,
    input  logic [2:0]          wr_sel,
    input  logic [7:0]          wr_data,
    input  logic [NCORES-1:0]   core_ack,
    input  logic                dist_pend,
    output logic [NCORES-1:0]   core_req,
    output logic [NCORES-1:0]   core_asleep,
    output logic [NCORES-1:0]   core_lpi,
    output logic [2*NCORES-1:0] core_grp,
    output logic                gs_req,
    output logic                gs_done,
    output logic                attr_lock,
    output logic [5:0]          attr,
    output logic [7:0]          dist_ctl,
    output logic                err_valid,
    output logic                err_ovf,
    output logic [7:0]          err_syn,
    output logic [3:0]          err_sev,
    output logic [8:0]          err_info
);
    logic [NCORES-1:0] v_busy, v_lpi, e_grp;
    logic              gs_req_q, gs_done_q, all_asleep, locked;
    logic [5:0]        attr_q;
    logic [7:0]        dctl_q;
    logic              wr_attr, wr_gs, wr_dctl, clr;
    logic              viol_attr, viol_gs, viol_dctl;
    logic [INFO_W-1:0] core_info;
    err_ev_t           ev;

    for (genvar i = 0; i < NCORES; i++) begin : g_core
        sleep_guard_core u_core (
            .clk         (clk),
            .rst         (rst),
            .hit_i       (wr_en && (wr_core == CORE_W'(i))),
            .sel_i       (wr_sel),
            .data_i      (wr_data[1:0]),
            .ack_i       (core_ack[i]),
            .req_o       (core_req[i]),
            .asleep_o    (core_asleep[i]),
            .lpi_o       (core_lpi[i]),
            .grp_o       (core_grp[2*i +: 2]),
            .viol_busy_o (v_busy[i]),
            .viol_lpi_o  (v_lpi[i]),
            .ev_grp_o    (e_grp[i])
        );
    end

    assign all_asleep = &(core_req & core_asleep);
    assign locked     = (|core_lpi) && !gs_done_q;
    assign wr_attr    = wr_en && (wr_sel == SEL_ATTR);
    assign wr_gs      = wr_en && (wr_sel == SEL_GSLEEP);
    assign wr_dctl    = wr_en && (wr_sel == SEL_DCTL);
    assign clr        = wr_en && (wr_sel == SEL_ERRCLR) && wr_data[0];
    assign viol_attr  = wr_attr && locked && (wr_data[5:0] != attr_q);
    assign viol_gs    = wr_gs && wr_data[0] && !all_asleep;
    assign viol_dctl  = wr_dctl && dist_pend;
    assign core_info  = INFO_W'(wr_core);

    always_ff @(posedge clk) begin
        if (rst) begin
            gs_req_q  <= 1'b0;
            gs_done_q <= 1'b0;
            attr_q    <= '0;
            dctl_q    <= '0;
        end else begin
            gs_done_q <= gs_req_q && all_asleep;
            if (wr_gs && !viol_gs) gs_req_q <= wr_data[0];
            if (wr_attr && !viol_attr) attr_q <= wr_data[5:0];
            if (wr_dctl && !viol_dctl) dctl_q <= wr_data;
        end
    end

    always_comb begin
        ev = '0;
        if (|v_busy)        ev = mk_ev(SYN_HS_BUSY, core_info);
        else if (|v_lpi)    ev = mk_ev(SYN_LPI_CLR, core_info);
        else if (|e_grp)    ev = mk_ev(SYN_GRP_DROP, core_info);
        else if (viol_attr) ev = mk_ev(SYN_ATTR_LOCK, core_info);
        else if (viol_gs)   ev = mk_ev(SYN_GS_FAIL, core_info);
        else if (viol_dctl) ev = mk_ev(SYN_DCTL_PEND, INFO_W'(wr_data));
    end

    sleep_guard_rec u_rec (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .clr_i   (clr),
        .valid_o (err_valid),
        .ovf_o   (err_ovf),
        .syn_o   (err_syn),
        .sev_o   (err_sev),
        .info_o  (err_info)
    );

    assign gs_req    = gs_req_q;
    assign gs_done   = gs_done_q;
    assign attr_lock = locked;
    assign attr      = attr_q;
    assign dist_ctl  = dctl_q;

    AST_ATTR_LOCK: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(attr_q)); // R5
    AST_DCTL_PEND: assert property (@(posedge clk) disable iff (rst)
        dist_pend |=> $stable(dctl_q)); // R8
    AST_GS_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !gs_req_q |=> !gs_done_q); // R4
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|v_busy, |v_lpi, |e_grp, viol_attr, viol_gs, viol_dctl})); // R9
endmodule

// File: tb/sim_sleep_guard.sv
module sim_sleep_guard;
    localparam int N = 4;
    localparam int CW = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [CW-1:0]  wr_core = '0;
    logic [2:0]     wr_sel = '0;
    logic [7:0]     wr_data = '0;
    logic [N-1:0]   core_ack = '0;
    logic           dist_pend = 1'b0;
    logic [N-1:0]   core_req, core_asleep, core_lpi;
    logic [2*N-1:0] core_grp;
    logic           gs_req, gs_done, attr_lock, err_valid, err_ovf;
    logic [5:0]     attr;
    logic [7:0]     dist_ctl, err_syn;
    logic [3:0]     err_sev;
    logic [8:0]     err_info;
    int             n_chk = 0;
    int             n_fail = 0;

    always #5 clk = ~clk;

    sleep_guard #(.NCORES(N)) u0 (.*);

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic chk_rec(input string r, input logic [7:0] syn, input logic [8:0] info);
        chk(r, {31'b0, err_valid}, 1);
        chk(r, {24'b0, err_syn}, {24'b0, syn});
        chk(r, {28'b0, err_sev}, 32'hF);
        chk(r, {23'b0, err_info}, {23'b0, info});
    endtask

    task automatic wr(input int core, input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_core = CW'(core); wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack(input logic [N-1:0] m);
        @(negedge clk);
        core_ack = m;
        @(negedge clk);
        core_ack = '0;
    endtask

    task automatic clear_err();
        wr(0, 3'd6, 8'h01);
        chk("R9 clear", {30'b0, err_valid, err_ovf}, 0);
    endtask

    task automatic t_reset();
        chk("R1 core bits", {20'b0, core_req, core_asleep, core_lpi}, 0);
        chk("R1 grp", {24'b0, core_grp}, 0);
        chk("R1 global", {29'b0, gs_req, gs_done, attr_lock}, 0);
        chk("R1 attr/dctl", {18'b0, attr, dist_ctl}, 0);
        chk("R1 record", {30'b0, err_valid, err_ovf}, 0);
    endtask

    task automatic t_handshake();
        wr(1, 3'd0, 8'h01);
        chk("R2 accept", {28'b0, core_req}, 32'h2);
        chk("R2 no err", {31'b0, err_valid}, 0);
        wr(1, 3'd0, 8'h00);
        chk("R2 busy drop", {28'b0, core_req}, 32'h2);
        chk_rec("R2 syn07", 8'h07, 9'h001);
        repeat (3) @(negedge clk);
        chk("R3 no ack hold", {28'b0, core_asleep}, 0);
        ack(4'b0010);
        chk("R3 ack follow", {28'b0, core_asleep}, 32'h2);
        clear_err();
    endtask

    task automatic t_group();
        wr(2, 3'd2, 8'h03);
        chk("R7 grp set", {24'b0, core_grp}, 32'h30);
        wr(2, 3'd0, 8'h01);
        chk("R7 sleep taken", {28'b0, core_req}, 32'h6);
        chk("R7 grp cleared", {24'b0, core_grp}, 0);
        chk_rec("R7 syn09", 8'h09, 9'h002);
        clear_err();
    endtask

    task automatic t_lpi();
        wr(0, 3'd1, 8'h01);
        chk("R6 enable", {28'b0, core_lpi}, 32'h1);
        wr(0, 3'd1, 8'h00);
        chk("R6 clear dropped", {28'b0, core_lpi}, 32'h1);
        chk_rec("R6 syn06", 8'h06, 9'h000);
        clear_err();
    endtask

    task automatic t_attr_locked();
        chk("R5 lock on", {31'b0, attr_lock}, 1);
        wr(3, 3'd3, 8'h15);
        chk("R5 attr held", {26'b0, attr}, 0);
        chk_rec("R5 syn05 R10", 8'h05, 9'h003);
        clear_err();
        wr(3, 3'd3, 8'h00);
        chk("R5 same value no err", {31'b0, err_valid}, 0);
    endtask

    task automatic t_global();
        wr(0, 3'd4, 8'h01);
        chk("R4 reject req", {31'b0, gs_req}, 0);
        chk_rec("R4 syn08", 8'h08, 9'h000);
        clear_err();
        wr(0, 3'd0, 8'h01);
        wr(3, 3'd0, 8'h01);
        ack(4'b1101);
        chk("R3 all asleep", {24'b0, core_req, core_asleep}, 32'hFF);
        wr(1, 3'd4, 8'h01);
        chk("R4 req set", {30'b0, gs_req, gs_done}, 32'h2);
        chk("R4 no err", {31'b0, err_valid}, 0);
        @(negedge clk);
        chk("R4 done next cycle", {31'b0, gs_done}, 1);
        chk("R5 unlocked", {31'b0, attr_lock}, 0);
        wr(2, 3'd3, 8'h15);
        chk("R5 write after sleep", {26'b0, attr}, 32'h15);
        chk("R5 no err", {31'b0, err_valid}, 0);
    endtask

    task automatic t_dist();
        dist_pend = 1'b1;
        wr(1, 3'd5, 8'hA5);
        chk("R8 dropped", {24'b0, dist_ctl}, 0);
        chk_rec("R8 syn0A R10", 8'h0A, 9'h0A5);
        wr(1, 3'd5, 8'h3C);
        chk("R9 overflow", {31'b0, err_ovf}, 1);
        chk_rec("R9 first kept", 8'h0A, 9'h0A5);
        clear_err();
        dist_pend = 1'b0;
        wr(1, 3'd5, 8'h3C);
        chk("R8 accepted", {24'b0, dist_ctl}, 32'h3C);
        chk("R8 no err", {31'b0, err_valid}, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_handshake();
        t_group();
        t_lpi();
        t_attr_locked();
        t_global();
        t_dist();
        finish_run();
    end
endmodule